// File: doc/BRIEF.md
# Interleaved Bubble-Tolerant Thermometer Encoder

This block turns the 15-tap thermometer words of a two-channel time-interleaved flash converter into 4-bit binary samples. Each channel registers its thermometer word, forms a 4-bit Gray code straight from the thermometer taps, and converts that Gray code to binary. A merge stage then interleaves the two channels' results into one stream at the full master-clock rate.

The Gray stage computes each Gray bit as the parity of a fixed tap subset. On a clean thermometer word this gives the Gray code of the ones count. A stray bit, such as one left by a comparator glitch, flips exactly one Gray bit, so the damage is bounded and predictable. A flip on an even tap, which is the most frequent tap class, moves the result by only one code.

Both channels and the merge run from a single master clock. An internal phase bit alternates which channel captures on each edge. Each channel therefore takes a new word every second cycle, and the output carries a new sample every cycle.

Top module: `therm_interleaved_encoder`

## Requirements
- R1: When `rst` is high at a rising edge, `code_out` is 0 after that edge. The phase also restarts, so the first edge with `rst` low is an even-channel capture edge.
- R2: A clean thermometer word with taps 0 to n-1 set and the rest clear (n from 0 to 15) is encoded as the binary value n.
- R3: The all-clear word gives code 0 and the all-set word gives code 15.
- R4: For any word, Gray bit j is the parity of the set taps whose index has exactly j trailing one bits. Gray bit 0 covers taps 0,2,4,...,14; bit 1 covers taps 1,5,9,13; bit 2 covers taps 3,11; bit 3 covers tap 7. Binary bit j is the XOR of Gray bits j through 3. As a result, flipping a single tap i of a clean word of count n yields n XOR (2^(k+1)-1), where k is the number of trailing ones of i.
- R5: A clean word of count n with a single flipped tap at an even index produces a code exactly one away from n.
- R6: The even channel captures `therm_even` on the first edge after reset release and on every second edge after that. The odd channel captures `therm_odd` on the remaining edges.
- R7: `code_out` alternates strictly between the even and odd channels. Each result appears after the third rising edge following the edge that captured its word.
- R8: The value on a channel's input during an edge on which that channel does not capture has no effect on `code_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| therm_even | input | 15 | Thermometer word for the even-phase channel, tap 0 lowest |
| therm_odd | input | 15 | Thermometer word for the odd-phase channel, tap 0 lowest |
| code_out | output | 4 | Interleaved binary sample stream, one per clock |

## Verification
The bench drives clean thermometer ramps upward on one channel and downward on the other. These ramps separate a correct ones-count mapping (including both full-scale ends) from a swapped or mis-timed channel. It then sweeps every single-tap flip of every clean count. The flips exercise all four Gray tap classes, so a wrong tap assignment or a wrong Gray-to-binary fold shows up as a code distinct from the clean one. The channel that is not capturing always sees random noise, which exposes any capture on the wrong phase. A reset in mid-stream shows the phase and pipeline restarting.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

    // Default geometry of the comparator bank and the resulting code width
    localparam int TAPS_DEF   = 15;
    localparam int CODE_W_DEF = $clog2(TAPS_DEF + 1);
    localparam int NUM_CH     = 2;

    // Which interleaved channel a sample belongs to
    typedef enum logic {
        CH_EVEN = 1'b0,
        CH_ODD  = 1'b1
    } chan_e;

    // One merged output sample with its origin
    typedef struct packed {
        logic [CODE_W_DEF-1:0] code;
        chan_e                 src;
    } sample_s;

    // Number of consecutive one bits starting at bit 0 of idx;
    // selects the Gray bit a thermometer tap feeds
    function automatic int trail_ones(input int idx);
        int cnt;
        cnt = 0;
        for (int b = 0; b < 31; b++) begin
            if ((((idx >> b) & 1) == 1) && (cnt == b)) begin
                cnt++;
            end
        end
        return cnt;
    endfunction

endpackage

// File: rtl/therm_capture.sv
module therm_capture #(
    parameter int TAPS = thermo_pkg::TAPS_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [TAPS-1:0] d,
    output logic [TAPS-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    // R8
    hold_off_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

endmodule

// File: rtl/therm_gray_enc.sv
module therm_gray_enc #(
    parameter int TAPS   = thermo_pkg::TAPS_DEF,
    parameter int CODE_W = $clog2(TAPS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAPS-1:0]   therm,
    output logic [CODE_W-1:0] gray
);
    import thermo_pkg::*;

    logic [CODE_W-1:0] gray_d;

    // Each Gray bit is the parity of the taps whose index ends in j ones
    for (genvar j = 0; j < CODE_W; j++) begin : g_bit
        logic par;
        always_comb begin
            par = 1'b0;
            for (int i = 0; i < TAPS; i++) begin
                if (trail_ones(i) == j) begin
                    par = par ^ therm[i];
                end
            end
        end
        assign gray_d[j] = par;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gray <= '0;
        end else begin
            gray <= gray_d;
        end
    end

endmodule

// File: rtl/gray_bin_dec.sv
module gray_bin_dec #(
    parameter int CODE_W = thermo_pkg::CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] gray,
    output logic [CODE_W-1:0] bin
);

    logic [CODE_W-1:0] bin_d;

    // Binary bit j folds every Gray bit from j upward
    for (genvar j = 0; j < CODE_W; j++) begin : g_fold
        assign bin_d[j] = ^gray[CODE_W-1:j];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bin <= '0;
        end else begin
            bin <= bin_d;
        end
    end

endmodule

// File: rtl/therm_channel.sv
module therm_channel #(
    parameter int TAPS   = thermo_pkg::TAPS_DEF,
    parameter int CODE_W = $clog2(TAPS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [TAPS-1:0]   therm_in,
    output logic [CODE_W-1:0] bin_out
);

    logic [TAPS-1:0]   cap_q;
    logic [CODE_W-1:0] gray_q;

    therm_capture #(.TAPS(TAPS)) u_cap (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (therm_in),
        .q    (cap_q)
    );

    therm_gray_enc #(.TAPS(TAPS), .CODE_W(CODE_W)) u_gray (
        .clk   (clk),
        .rst   (rst),
        .therm (cap_q),
        .gray  (gray_q)
    );

    gray_bin_dec #(.CODE_W(CODE_W)) u_bin (
        .clk  (clk),
        .rst  (rst),
        .gray (gray_q),
        .bin  (bin_out)
    );

    // R2
    clean_count_chk: assert property (@(posedge clk) disable iff (rst)
        (((cap_q + 1'b1) & cap_q) == '0) |=> ##1
        (bin_out == CODE_W'($countones($past(cap_q, 2)))));

    // R3
    full_scale_chk: assert property (@(posedge clk) disable iff (rst)
        (&cap_q) |=> ##1 (&bin_out));

endmodule

// File: rtl/interleave_merge.sv
module interleave_merge #(
    parameter int CODE_W = thermo_pkg::CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  thermo_pkg::chan_e phase,
    input  logic [CODE_W-1:0] bin_even,
    input  logic [CODE_W-1:0] bin_odd,
    output logic [CODE_W-1:0] code_out
);
    import thermo_pkg::*;

    logic [CODE_W-1:0] code_q;
    chan_e             src_q;

    // A word captured on an even edge is ready three edges later,
    // when the phase reads odd, and the reverse for the odd channel
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            src_q  <= CH_ODD;
        end else if (phase == CH_ODD) begin
            code_q <= bin_even;
            src_q  <= CH_EVEN;
        end else begin
            code_q <= bin_odd;
            src_q  <= CH_ODD;
        end
    end

    assign code_out = code_q;

    // R7
    alternate_src_chk: assert property (@(posedge clk) disable iff (rst)
        (src_q == CH_EVEN) |=> (src_q == CH_ODD));

endmodule

// File: rtl/therm_interleaved_encoder.sv
module therm_interleaved_encoder #(
    parameter int TAPS   = thermo_pkg::TAPS_DEF,
    parameter int CODE_W = $clog2(TAPS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAPS-1:0]   therm_even,
    input  logic [TAPS-1:0]   therm_odd,
    output logic [CODE_W-1:0] code_out
);
    import thermo_pkg::*;

    chan_e             phase;
    logic [TAPS-1:0]   ch_in  [NUM_CH];
    logic [CODE_W-1:0] ch_bin [NUM_CH];

    assign ch_in[0] = therm_even;
    assign ch_in[1] = therm_odd;

    // Half-rate capture phase derived from the master clock
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= CH_EVEN;
        end else begin
            phase <= (phase == CH_EVEN) ? CH_ODD : CH_EVEN;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic load;
        assign load = (phase == ((c == 0) ? CH_EVEN : CH_ODD));
        therm_channel #(.TAPS(TAPS), .CODE_W(CODE_W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .therm_in (ch_in[c]),
            .bin_out  (ch_bin[c])
        );
    end

    interleave_merge #(.CODE_W(CODE_W)) u_merge (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .bin_even (ch_bin[0]),
        .bin_odd  (ch_bin[1]),
        .code_out (code_out)
    );

    // R6
    phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == CH_EVEN) |=> (phase == CH_ODD));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (code_out == '0));

endmodule

// File: tb/therm_interleaved_encoder_tb.sv
module therm_interleaved_encoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TAPS       = 15;

    typedef struct {
        int    exp_code;
        string tag;
        int    ideal;
        bit    even_bubble;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [TAPS-1:0] therm_even = '0;
    logic [TAPS-1:0] therm_odd  = '0;
    logic [3:0]      code_out;

    int   checks = 0;
    int   errors = 0;
    int   k      = 0;
    bit   done   = 1'b0;
    exp_t q[$];

    therm_interleaved_encoder u_dut (
        .clk        (clk),
        .rst        (rst),
        .therm_even (therm_even),
        .therm_odd  (therm_odd),
        .code_out   (code_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference: each set tap contributes a mask of (trailing ones + 1) low bits
    function automatic int enc_ref(input logic [TAPS-1:0] w);
        int r;
        r = 0;
        for (int i = 0; i < TAPS; i++) begin
            if (w[i]) begin
                int t;
                int v;
                t = 0;
                v = i;
                while (v % 2 == 1) begin
                    t++;
                    v = v / 2;
                end
                r = r ^ ((2 << t) - 1);
            end
        end
        return r & 15;
    endfunction

    function automatic logic [TAPS-1:0] clean(input int n);
        logic [TAPS-1:0] w;
        w = '0;
        for (int i = 0; i < n; i++) w[i] = 1'b1;
        return w;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: code_out=%0d expected %0d (cycle %0d)", tag, act, exp, k);
        end
    endtask

    // One master cycle: the word goes to whichever channel captures on this
    // edge (R6), the other channel gets noise that must be ignored (R8),
    // and the output three edges on must carry it (R7).
    task automatic step(input logic [TAPS-1:0] w, input string tag,
                        input int ideal, input bit even_bubble);
        exp_t e;
        if (k % 2 == 0) begin
            therm_even = w;
            therm_odd  = TAPS'($urandom);
        end else begin
            therm_odd  = w;
            therm_even = TAPS'($urandom);
        end
        @(posedge clk);
        e.exp_code    = enc_ref(w);
        e.tag         = tag;
        e.ideal       = ideal;
        e.even_bubble = even_bubble;
        q.push_back(e);
        k++;
        @(negedge clk);
        if (q.size() == 4) begin
            e = q.pop_front();
            check(e.tag, int'(code_out), e.exp_code);
            if (e.even_bubble) begin
                // R5: even-tap bubble lands exactly one code away
                int d;
                d = int'(code_out) - e.ideal;
                checks++;
                if (d != 1 && d != -1) begin
                    errors++;
                    $display("FAIL R5: code_out=%0d expected %0d +/- 1", code_out, e.ideal);
                end
            end
        end else begin
            // R1 / R7: pipeline still holds reset values
            check("R1", int'(code_out), 0);
        end
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        therm_even = '1;
        therm_odd  = '1;
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk);
            @(negedge clk);
            // R1
            check("R1", int'(code_out), 0);
        end
        rst = 1'b0;
        k = 0;
        q.delete();
    endtask

    task automatic flush();
        for (int c = 0; c < 4; c++) step('0, "R3", 0, 1'b0);
    endtask

    initial begin
        do_reset(3);

        // R2 / R3: clean ramp up on even channel, down on odd channel
        for (int n = 0; n <= 15; n++) begin
            step(clean(n), (n == 0 || n == 15) ? "R3" : "R2", n, 1'b0);
            step(clean(15 - n), (n == 0 || n == 15) ? "R3" : "R2", 15 - n, 1'b0);
        end
        flush();

        // R1: reset in mid-stream restarts phase and clears the pipeline
        step(clean(9), "R2", 9, 1'b0);
        step(clean(4), "R2", 4, 1'b0);
        do_reset(1);
        for (int n = 15; n >= 0; n--) step(clean(n), "R2", n, 1'b0);
        flush();

        // R4 / R5: every single-tap flip of every clean count
        for (int n = 0; n <= 15; n++) begin
            for (int i = 0; i < TAPS; i++) begin
                logic [TAPS-1:0] w;
                w = clean(n) ^ (TAPS'(1) << i);
                if (i == n || i == n - 1) begin
                    step(w, "R2", (i == n) ? n + 1 : n - 1, 1'b0);
                end else begin
                    step(w, "R4", n, (i % 2 == 0));
                end
            end
        end
        flush();

        // R8: random noise on both inputs, only captured words matter
        for (int c = 0; c < 40; c++) begin
            step(TAPS'($urandom), "R8", 0, 1'b0);
        end
        flush();

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule